// File: doc/BRIEF.md
# Voted Data-Valid Alignment Delay

This block delays a front-end data-valid strobe so that it lines up with sample words coming out of a converter with a fixed pipeline latency. Each triggered event is then framed correctly before it is handed to a serializer. The strobe and the sample word both pass through pipelines of equal depth and leave the block in the same cycle. At a 40 MHz clock the default depth of 8 stages gives 200 ns. The depth has to be exact: one stage too few puts the strobe one cycle ahead of its data.

The strobe delay line is built three times. Each stage of the output is the bitwise majority of the three copies, and the voted value is written back into every copy on each clock. An upset in one copy is therefore outvoted at once and gone after the next edge. A one-cycle flag reports each disagreement so that upsets can be counted under irradiation.

While the strobe is low the output word is forced to zero. An output run limiter makes sure that an idle frame follows every event, even when the input strobe has no gap.

Top module: `dv_align_tmr`

## Requirements
- R1: `dv_o` reproduces `dv_i` delayed by exactly DEPTH clock cycles (default 8). A strobe present on the input in cycle n appears on the output in cycle n+DEPTH.
- R2: Whenever `dv_o` is high, `data_o` carries the `data_i` word that was applied in the same cycle as the strobe bit now being shown.
- R3: A single wrong bit in one copy of the strobe line, at any stage, never changes `dv_o` or `data_o`. The next clock edge overwrites it with the voted value, so a second upset one stage further down in another copy on the following cycle also has no effect.
- R4: While `dv_o` is low, `data_o` is all zeros.
- R5: After FRAME_MAX (default 16) consecutive high output cycles, `dv_o` is forced low for one cycle and that cycle's word is dropped, giving zeros. Gaps in the input strobe reach the output unchanged, so every event is followed by at least one cycle with `dv_o` low.
- R6: `seu_o` is high for exactly one cycle after each clock edge at which some stage had one copy that disagreed with the other two. Otherwise it is low.
- R7: While `rst_ni` is low, and for the first DEPTH cycles after it is released, `dv_o` and `seu_o` are low and `data_o` is zero, whatever `dv_i` is doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dv_i | input | 1 | Raw data-valid strobe from the front end |
| data_i | input | DATA_W | Digitized sample word |
| dv_o | output | 1 | Delayed, voted and gap-limited data-valid |
| data_o | output | DATA_W | Sample word aligned to `dv_o`, zero when idle |
| seu_o | output | 1 | One-cycle pulse when a copy disagreement was seen |

## Verification
Three functions can act in the same cycle: the run limiter cutting a long event, the voter masking an upset, and the error flag. The bench drives an unbroken strobe longer than FRAME_MAX and, through a brief force, flips a bit in one copy on the edge just before the cut. The output must then show the cut with a zero word, with no upset showing through, and `seu_o` must pulse in the very next cycle. A second pair of upsets in two copies on consecutive cycles, one stage apart, tells true scrubbing apart from plain voting, because a missing write-back would let the two faults line up into a majority.

// File: rtl/dv_align_pkg.sv
package dv_align_pkg;
  localparam int unsigned COPIES = 3;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/tmr_vote.sv
module tmr_vote
  import dv_align_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] maj_o,
  output logic [W-1:0] diff_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign maj_o[b]  = maj3(a_i[b], b_i[b], c_i[b]);
    assign diff_o[b] = (a_i[b] ^ b_i[b]) | (a_i[b] ^ c_i[b]);
  end
endmodule

// File: rtl/dv_copy.sv
module dv_copy #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] line_d_i,
  output logic [DEPTH-1:0] line_q_o
);
  logic [DEPTH-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_d_i;
  end

  assign line_q_o = line_q;
endmodule

// File: rtl/word_pipe.sv
module word_pipe #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= word_i;
      for (int k = 1; k < DEPTH; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign word_o = stage_q[DEPTH-1];
endmodule

// File: rtl/frame_gap.sv
module frame_gap #(
  parameter int unsigned FRAME_MAX = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic pass_o
);
  localparam int unsigned CW = $clog2(FRAME_MAX + 1);

  logic [CW-1:0] run_q;
  logic          at_cap;

  // run_q counts earlier consecutive high outputs
  assign at_cap = (run_q == CW'(FRAME_MAX));
  assign pass_o = raw_i & ~at_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               run_q <= '0;
    else if (!raw_i || at_cap) run_q <= '0;
    else                       run_q <= run_q + CW'(1);
  end

  assert_gap_after_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o && run_q == CW'(FRAME_MAX - 1)) |=> !pass_o);

  assert_run_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= CW'(FRAME_MAX));
endmodule

// File: rtl/dv_align_tmr.sv
module dv_align_tmr
  import dv_align_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned FRAME_MAX = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dv_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              dv_o,
  output logic [DATA_W-1:0] data_o,
  output logic              seu_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]  line_q [COPIES];
  logic [DEPTH-1:0]  voted;
  logic [DEPTH-1:0]  diff;
  logic [DEPTH-1:0]  line_d;
  logic [DATA_W-1:0] word_late;
  logic              dv_pass;
  logic              seu_q;

  for (genvar i = 0; i < COPIES; i++) begin : g_rep
    dv_copy #(.DEPTH(DEPTH)) u_copy (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .line_d_i (line_d),
      .line_q_o (line_q[i])
    );
  end

  tmr_vote #(.W(DEPTH)) u_vote (
    .a_i    (line_q[0]),
    .b_i    (line_q[1]),
    .c_i    (line_q[2]),
    .maj_o  (voted),
    .diff_o (diff)
  );

  // voted value shifts into all copies: scrub on every edge
  if (DEPTH > 1) begin : g_deep
    assign line_d = {voted[DEPTH-2:0], dv_i};
  end else begin : g_flat
    assign line_d = dv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seu_q <= 1'b0;
    else         seu_q <= |diff;
  end

  word_pipe #(.DEPTH(DEPTH), .W(DATA_W)) u_word (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (data_i),
    .word_o (word_late)
  );

  frame_gap #(.FRAME_MAX(FRAME_MAX)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (voted[DEPTH-1]),
    .pass_o (dv_pass)
  );

  assign dv_o   = dv_pass;
  assign data_o = dv_pass ? word_late : '0;
  assign seu_o  = seu_q;

  // cycles since reset release, saturating at DEPTH
  logic [CNT_W-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    since_q <= '0;
    else if (since_q != CNT_W'(DEPTH)) since_q <= since_q + CNT_W'(1);
  end

  assert_quiet_after_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q < CNT_W'(DEPTH)) |-> !dv_o);

  for (genvar k = 1; k < DEPTH; k++) begin : g_chk
    assert_stage_shift_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      voted[k] == $past(voted[k-1]));
  end
endmodule

// File: tb/sim_dv_align_tmr.sv
module sim_dv_align_tmr;
  localparam int DEPTH = 8;
  localparam int DW    = 8;
  localparam int FMAX  = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          dv_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          dv_o;
  logic [DW-1:0] data_o;
  logic          seu_o;

  int vectors = 0;
  int miscompares = 0;

  logic          hist_dv [DEPTH];
  logic [DW-1:0] hist_d  [DEPTH];
  int            run_m;
  logic          err_m;

  always #10 clk = ~clk;

  dv_align_tmr #(.DEPTH(DEPTH), .DATA_W(DW), .FRAME_MAX(FMAX)) u0 (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .dv_i   (dv_i),
    .data_i (data_i),
    .dv_o   (dv_o),
    .data_o (data_o),
    .seu_o  (seu_o)
  );

  task automatic compare(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < DEPTH; k++) begin
      hist_dv[k] = 1'b0;
      hist_d[k]  = '0;
    end
    run_m = 0;
    err_m = 1'b0;
  endtask

  task automatic drive_push(input logic dv, input logic [DW-1:0] d);
    for (int k = DEPTH - 1; k > 0; k--) begin
      hist_dv[k] = hist_dv[k-1];
      hist_d[k]  = hist_d[k-1];
    end
    hist_dv[0] = dv;
    hist_d[0]  = d;
    dv_i   = dv;
    data_i = d;
  endtask

  // one cycle: check outputs at negedge against the model, then drive
  task automatic step(input logic dv, input logic [DW-1:0] d, input string tag);
    logic          raw;
    logic          edv;
    logic [DW-1:0] ed;
    @(negedge clk);
    raw = hist_dv[DEPTH-1];
    if (raw && run_m == FMAX) begin
      edv = 1'b0; run_m = 0;
    end else if (raw) begin
      edv = 1'b1; run_m++;
    end else begin
      edv = 1'b0; run_m = 0;
    end
    ed = edv ? hist_d[DEPTH-1] : '0;
    compare(tag, "dv_o", int'(dv_o), int'(edv));
    compare(tag, "data_o", int'(data_o), int'(ed));
    compare(tag, "seu_o", int'(seu_o), int'(err_m));
    err_m = 1'b0;
    drive_push(dv, d);
  endtask

  // single event upset: flip state of one copy between edges
  task automatic upset(input int cp, input logic [DEPTH-1:0] v);
    #2;
    case (cp)
      0:       force u0.g_rep[0].u_copy.line_q = v;
      1:       force u0.g_rep[1].u_copy.line_q = v;
      default: force u0.g_rep[2].u_copy.line_q = v;
    endcase
    #1;
    case (cp)
      0:       release u0.g_rep[0].u_copy.line_q;
      1:       release u0.g_rep[1].u_copy.line_q;
      default: release u0.g_rep[2].u_copy.line_q;
    endcase
    err_m = 1'b1;
  endtask

  task automatic do_reset(input logic dv_during);
    @(negedge clk);
    rst_ni = 1'b0;
    dv_i   = dv_during;
    data_i = 8'hA5;
    model_clear();
    repeat (3) begin
      @(negedge clk);
      compare("R7", "dv_o", int'(dv_o), 0);
      compare("R7", "data_o", int'(data_o), 0);
      compare("R7", "seu_o", int'(seu_o), 0);
    end
    rst_ni = 1'b1;
    drive_push(dv_during, 8'hA5);
  endtask

  task automatic flush(input string tag);
    repeat (DEPTH + 2) step(1'b0, 8'h00, tag);
  endtask

  task automatic t_reset_quiet();
    do_reset(1'b1);
    for (int i = 0; i < DEPTH + 4; i++) step(1'b1, DW'(8'h10 + i), "R7");
    flush("R7");
  endtask

  task automatic t_events();
    int n = 0;
    for (int len = 1; len <= 5; len += 2) begin
      for (int i = 0; i < len; i++) begin
        step(1'b1, DW'(n * 37 + 3), "R1 R2");
        n++;
      end
      step(1'b0, 8'hEE, "R4");
      step(1'b0, 8'h77, "R4");
    end
    flush("R1 R4");
  endtask

  task automatic t_gap_cut();
    for (int i = 0; i < 20; i++) step(1'b1, DW'(8'h40 + i), "R5");
    flush("R5");
  endtask

  task automatic t_gap_propagate();
    for (int i = 0; i < 4; i++) step(1'b1, DW'(8'h80 + i), "R5 R1");
    step(1'b0, 8'hFF, "R5");
    for (int i = 0; i < 4; i++) step(1'b1, DW'(8'h90 + i), "R5 R1");
    flush("R5");
  endtask

  task automatic t_upset_idle();
    step(1'b0, 8'h00, "R6");
    upset(0, DEPTH'(1) << 3);
    step(1'b0, 8'h00, "R3 R6");
    upset(2, DEPTH'(1) << (DEPTH - 2));
    step(1'b0, 8'h00, "R3 R6");
    flush("R3 R6");
  endtask

  task automatic t_upset_scrub();
    step(1'b0, 8'h00, "R3");
    upset(1, DEPTH'(1) << 2);
    step(1'b0, 8'h00, "R3 R6");
    upset(2, DEPTH'(1) << 3);
    flush("R3");
  endtask

  task automatic t_upset_busy();
    for (int i = 0; i < 24; i++) begin
      step(1'b1, DW'(8'hC0 + i), "R3 R5");
      if (i == DEPTH + 1)      upset(1, ~(DEPTH'(1) << (DEPTH - 2)));
      else if (i == 15 + DEPTH) upset(0, ~(DEPTH'(1) << (DEPTH - 2)));
    end
    flush("R3 R5 R6");
  endtask

  task automatic t_reset_mid();
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, DW'(8'h20 + i), "R7");
    do_reset(1'b0);
    flush("R7");
  endtask

  initial begin
    model_clear();
    t_reset_quiet();
    t_events();
    t_gap_cut();
    t_gap_propagate();
    t_upset_idle();
    t_upset_scrub();
    t_upset_busy();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule